// File: doc/BRIEF.md
# ATA Device Task-File Register Block

This block is the device-side register file of a parallel ATA disk controller. The host reaches it through a 4-bit register address, read and write enables and a 16-bit data bus. Address bit 3 separates the command block (bit 3 = 0) from the control block (bit 3 = 1). The block stores the device control settings and the device/head selection. It produces the soft-reset level, a gated interrupt line toward the host, the selected head, the addressing-mode flag and a flag that says this unit is the addressed device. It also builds a read-only drive address word from the live selection, head and write-gate state.

Data-register accesses connect the host bus to a sector buffer through pop and push strobes. These strobes are qualified by the data-request input. In byte-transfer mode only the low lane carries data. Read data is combinational and comes with a per-bit output-enable mask. A bit whose mask is 0 is left floating by the pad logic.

Register map used below: 0x0 data, 0x6 device/head, 0x7 command/status, 0xE device control (write), 0xF drive address (read).

Top module: `ata_taskfile_regs`

## Requirements
- R1: After reset, soft_rst, hob and host_intrq are 0, and a read of 0x6 returns 0x00A0 (head 0, device 0, CHS mode).
- R2: A write to 0xE captures bit 7 as hob, bit 2 as the soft-reset level and bit 1 as the interrupt mask (1 = masked). The new values are visible from the clock edge that takes the write.
- R3: A write to any command-block address (0x0 to 0x7) clears hob at that edge.
- R4: intrq_req sets a pending flag at the next edge. host_intrq is 1 only while the flag is set, the mask bit is 0 and the device bit of 0x6 equals dev_strap.
- R5: A read of 0x7 returns drq at bit 3 and zeros elsewhere, with mask 0x00FF. It clears the pending interrupt at that edge.
- R6: While soft reset is 1, hob and the pending flag are cleared at every edge, intrq_req is ignored and the device/head contents are kept. A device-control write with bit 7 set made during soft reset leaves hob at 0.
- R7: A write to 0x6 takes bits 3:0 as head, bit 4 as device (0 = device 0, 1 = device 1) and bit 6 as mode (1 = LBA). Reads of 0x6 force bits 7 and 5 to 1, with mask 0x00FF.
- R8: A read of 0xF returns: bit 7 not driven (mask 0x007F); bit 6 = NOT media_wr_busy; bits 5:2 = one's complement of the head, with bit 2 the LSB; bit 1 = 0 only when device 1 is addressed and soft reset is 0; bit 0 = 0 only when device 0 is addressed and soft reset is 0. The word reflects register state combinationally.
- R9: A read of 0x0 with drq = 1 returns buf_rdata with mask 0xFFFF and asserts buf_rd_pop. With ecc_byte = 1 it returns only the low byte, upper bits 0, with mask 0x00FF.
- R10: With drq = 0, a read of 0x0 returns 0 and does not assert buf_rd_pop, and a write to 0x0 does not assert buf_wr_push.
- R11: A write to 0x0 with drq = 1 asserts buf_wr_push with buf_wdata = wdata. With ecc_byte = 1 the upper byte of buf_wdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_strap | input | 1 | This unit's device number (0 or 1) |
| addr | input | 4 | Register address; bit 3 = control block |
| rd_en | input | 1 | Host read enable |
| wr_en | input | 1 | Host write enable |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Read data (combinational) |
| rdata_oe | output | 16 | Per-bit drive enable for rdata |
| drq | input | 1 | Data request qualifier |
| ecc_byte | input | 1 | Byte-wide data transfer mode |
| media_wr_busy | input | 1 | Media write in progress |
| intrq_req | input | 1 | Interrupt request pulse from the command engine |
| buf_rdata | input | 16 | Word at the sector buffer head |
| buf_rd_pop | output | 1 | Advance the buffer read pointer |
| buf_wr_push | output | 1 | Store buf_wdata into the buffer |
| buf_wdata | output | 16 | Word toward the buffer |
| soft_rst | output | 1 | Soft-reset level |
| host_intrq | output | 1 | Gated interrupt to host |
| hob | output | 1 | High-order-byte readback select |
| head | output | 4 | Selected head |
| lba_mode | output | 1 | 1 = LBA addressing |
| dev_selected | output | 1 | Device bit matches dev_strap |

## Verification
The hardest case to reach is the overlap between soft reset and pending state. An interrupt and hob must both be set at the moment soft reset begins, and a new request must then arrive while reset is still held. The stimulus first pulses intrq_req. It then issues one device-control write that sets hob and the soft-reset bit together, so both are live when reset takes effect. It pulses intrq_req again during reset and checks hob, host_intrq and the device/head readback before and after release. Interrupt gating by device selection is covered by rewriting the device bit while an interrupt is pending.

// File: rtl/ata_tf_pkg.sv
`timescale 1ns/1ps
package ata_tf_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 4;
  localparam int HEAD_W = 4;
  localparam int LANE_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA    = 4'h0,
    REG_DEVHEAD = 4'h6,
    REG_CMDSTAT = 4'h7,
    REG_DEVCTL  = 4'hE,
    REG_DRVADDR = 4'hF
  } reg_addr_e;

  localparam int STAT_DRQ_BIT = 3;
endpackage

// File: rtl/ata_tf_ctrl.sv
`timescale 1ns/1ps
module ata_tf_ctrl
  import ata_tf_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic          status_rd,
  input  logic          intrq_req,
  input  logic          dev_sel,
  output logic          soft_rst,
  output logic          hob,
  output logic          nien,
  output logic          host_intrq
);
  logic srst_q, srst_d;
  logic nien_q, nien_d;
  logic hob_q, hob_d;
  logic pend_q, pend_d;
  logic devctl_wr, cmd_wr;

  assign devctl_wr = wr_en && (addr == REG_DEVCTL);
  assign cmd_wr    = wr_en && !addr[AW-1];

  always_comb begin
    srst_d = srst_q;
    nien_d = nien_q;
    hob_d  = hob_q;
    pend_d = pend_q;
    if (devctl_wr) begin
      srst_d = wdata[2];
      nien_d = wdata[1];
      hob_d  = wdata[7];
    end
    if (cmd_wr)    hob_d  = 1'b0;
    if (status_rd) pend_d = 1'b0;
    if (intrq_req) pend_d = 1'b1;
    if (srst_q) begin
      hob_d  = 1'b0;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q <= 1'b0;
      nien_q <= 1'b0;
      hob_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      srst_q <= srst_d;
      nien_q <= nien_d;
      hob_q  <= hob_d;
      pend_q <= pend_d;
    end
  end

  assign soft_rst   = srst_q;
  assign hob        = hob_q;
  assign nien       = nien_q;
  assign host_intrq = pend_q && !nien_q && dev_sel;

  // R6: soft reset wipes hob and pending interrupt on the following edge
  a_r6_srst_clears_state: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (!hob_q && !pend_q));
  // R3: command-block write leaves hob cleared
  a_r3_cmd_wr_clears_hob: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> !hob_q);
  // R2: soft-reset level follows the written control bit
  a_r2_srst_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    devctl_wr |=> (srst_q == $past(wdata[2])));
endmodule

// File: rtl/ata_tf_devhead.sv
`timescale 1ns/1ps
module ata_tf_devhead
  import ata_tf_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int HW = HEAD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic          strap,
  output logic [HW-1:0] head,
  output logic          drv,
  output logic          lba,
  output logic          dev_sel,
  output logic [7:0]    devhead_rd
);
  logic          we;
  logic [HW-1:0] head_q, head_d;
  logic          drv_q, drv_d;
  logic          lba_q, lba_d;

  assign we = wr_en && (addr == REG_DEVHEAD);

  always_comb begin
    head_d = head_q;
    drv_d  = drv_q;
    lba_d  = lba_q;
    if (we) begin
      head_d = wdata[HW-1:0];
      drv_d  = wdata[4];
      lba_d  = wdata[6];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      drv_q  <= 1'b0;
      lba_q  <= 1'b0;
    end else begin
      head_q <= head_d;
      drv_q  <= drv_d;
      lba_q  <= lba_d;
    end
  end

  assign head       = head_q;
  assign drv        = drv_q;
  assign lba        = lba_q;
  assign dev_sel    = (drv_q == strap);
  assign devhead_rd = {1'b1, lba_q, 1'b1, drv_q, head_q};

  // R7: head field follows the written low nibble
  a_r7_head_capture: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (head_q == $past(wdata[HW-1:0])));
endmodule

// File: rtl/ata_tf_datapath.sv
`timescale 1ns/1ps
module ata_tf_datapath
  import ata_tf_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int LW = LANE_W
) (
  input  logic          drq,
  input  logic          ecc_byte,
  input  logic          rd_sel,
  input  logic          wr_sel,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] buf_rdata,
  output logic [DW-1:0] data_rd,
  output logic [DW-1:0] data_oe,
  output logic          buf_rd_pop,
  output logic          buf_wr_push,
  output logic [DW-1:0] buf_wdata
);
  localparam int LANES = DW / LW;
  logic [LANES-1:0] lane_on;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      if (l == 0) begin : g_low
        assign lane_on[l] = 1'b1;
      end else begin : g_high
        assign lane_on[l] = !ecc_byte;
      end
      assign data_rd[l*LW +: LW]   = (rd_sel && drq && lane_on[l]) ? buf_rdata[l*LW +: LW] : '0;
      assign data_oe[l*LW +: LW]   = {LW{rd_sel && lane_on[l]}};
      assign buf_wdata[l*LW +: LW] = lane_on[l] ? wdata[l*LW +: LW] : '0;
    end
  endgenerate

  assign buf_rd_pop  = rd_sel && drq;
  assign buf_wr_push = wr_sel && drq;
endmodule

// File: rtl/ata_tf_readmux.sv
`timescale 1ns/1ps
module ata_tf_readmux
  import ata_tf_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int HW = HEAD_W
) (
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data_rd,
  input  logic [DW-1:0] data_oe,
  input  logic [7:0]    devhead_rd,
  input  logic          drq,
  input  logic          media_wr_busy,
  input  logic [HW-1:0] head,
  input  logic          drv,
  input  logic          soft_rst,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] rdata_oe
);
  localparam int DA_W = HW + 4;
  logic [DA_W-1:0] drv_addr;

  generate
    for (genvar i = 0; i < HW; i++) begin : g_head_inv
      assign drv_addr[2+i] = ~head[i];
    end
  endgenerate
  assign drv_addr[DA_W-1] = 1'b0;
  assign drv_addr[DA_W-2] = ~media_wr_busy;
  assign drv_addr[1]      = ~(drv && !soft_rst);
  assign drv_addr[0]      = ~(!drv && !soft_rst);

  always_comb begin
    rdata    = '0;
    rdata_oe = '0;
    if (rd_en) begin
      case (addr)
        REG_DATA: begin
          rdata    = data_rd;
          rdata_oe = data_oe;
        end
        REG_DEVHEAD: begin
          rdata[7:0]    = devhead_rd;
          rdata_oe[7:0] = '1;
        end
        REG_CMDSTAT: begin
          rdata[STAT_DRQ_BIT] = drq;
          rdata_oe[7:0]       = '1;
        end
        REG_DRVADDR: begin
          rdata[DA_W-1:0]    = drv_addr;
          rdata_oe[DA_W-2:0] = '1;
        end
        default: begin
          rdata    = '0;
          rdata_oe = '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/ata_taskfile_regs.sv
`timescale 1ns/1ps
module ata_taskfile_regs
  import ata_tf_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int HW = HEAD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dev_strap,
  input  logic [AW-1:0] addr,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] rdata_oe,
  input  logic          drq,
  input  logic          ecc_byte,
  input  logic          media_wr_busy,
  input  logic          intrq_req,
  input  logic [DW-1:0] buf_rdata,
  output logic          buf_rd_pop,
  output logic          buf_wr_push,
  output logic [DW-1:0] buf_wdata,
  output logic          soft_rst,
  output logic          host_intrq,
  output logic          hob,
  output logic [HW-1:0] head,
  output logic          lba_mode,
  output logic          dev_selected
);
  logic [1:0]    rst_sync;
  logic          rst_n_int;
  logic          nien;
  logic          drv;
  logic [7:0]    devhead_rd;
  logic [DW-1:0] data_rd, data_oe;
  logic          status_rd, data_rsel, data_wsel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_int = rst_sync[1];

  assign status_rd = rd_en && (addr == REG_CMDSTAT);
  assign data_rsel = rd_en && (addr == REG_DATA);
  assign data_wsel = wr_en && (addr == REG_DATA);

  ata_tf_devhead #(.AW(AW), .HW(HW)) u_devhead (
    .clk(clk), .rst_n(rst_n_int), .wr_en(wr_en), .addr(addr),
    .wdata(wdata[7:0]), .strap(dev_strap), .head(head), .drv(drv),
    .lba(lba_mode), .dev_sel(dev_selected), .devhead_rd(devhead_rd)
  );

  ata_tf_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n_int), .wr_en(wr_en), .addr(addr),
    .wdata(wdata[7:0]), .status_rd(status_rd), .intrq_req(intrq_req),
    .dev_sel(dev_selected), .soft_rst(soft_rst), .hob(hob), .nien(nien),
    .host_intrq(host_intrq)
  );

  ata_tf_datapath #(.DW(DW), .LW(LANE_W)) u_data (
    .drq(drq), .ecc_byte(ecc_byte), .rd_sel(data_rsel), .wr_sel(data_wsel),
    .wdata(wdata), .buf_rdata(buf_rdata), .data_rd(data_rd), .data_oe(data_oe),
    .buf_rd_pop(buf_rd_pop), .buf_wr_push(buf_wr_push), .buf_wdata(buf_wdata)
  );

  ata_tf_readmux #(.AW(AW), .DW(DW), .HW(HW)) u_rmux (
    .rd_en(rd_en), .addr(addr), .data_rd(data_rd), .data_oe(data_oe),
    .devhead_rd(devhead_rd), .drq(drq), .media_wr_busy(media_wr_busy),
    .head(head), .drv(drv), .soft_rst(soft_rst), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  // R4: masked or unselected device never raises the host line
  a_r4_intr_gated: assert property (@(posedge clk) disable iff (!rst_n_int)
    (nien || !dev_selected) |-> !host_intrq);
  // R10: no buffer movement without the data request
  a_r10_no_move_without_drq: assert property (@(posedge clk) disable iff (!rst_n_int)
    !drq |-> (!buf_rd_pop && !buf_wr_push));
  // R8: top bit of the drive address word stays floating
  a_r8_drvaddr_bit7_float: assert property (@(posedge clk) disable iff (!rst_n_int)
    (rd_en && addr == REG_DRVADDR) |-> !rdata_oe[7]);
endmodule

// File: tb/ata_taskfile_regs_tb.sv
`timescale 1ns/1ps
module ata_taskfile_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        dev_strap;
  logic [3:0]  addr;
  logic        rd_en, wr_en;
  logic [15:0] wdata;
  logic [15:0] rdata, rdata_oe;
  logic        drq, ecc_byte, media_wr_busy, intrq_req;
  logic [15:0] buf_rdata;
  logic        buf_rd_pop, buf_wr_push;
  logic [15:0] buf_wdata;
  logic        soft_rst, host_intrq, hob;
  logic [3:0]  head;
  logic        lba_mode, dev_selected;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ata_taskfile_regs u_dut (
    .clk(clk), .rst_n(rst_n), .dev_strap(dev_strap), .addr(addr),
    .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .rdata_oe(rdata_oe), .drq(drq), .ecc_byte(ecc_byte),
    .media_wr_busy(media_wr_busy), .intrq_req(intrq_req),
    .buf_rdata(buf_rdata), .buf_rd_pop(buf_rd_pop), .buf_wr_push(buf_wr_push),
    .buf_wdata(buf_wdata), .soft_rst(soft_rst), .host_intrq(host_intrq),
    .hob(hob), .head(head), .lba_mode(lba_mode), .dev_selected(dev_selected)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d,
                    output logic push, output logic [15:0] bw);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    #5;
    push = buf_wr_push; bw = buf_wdata;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wrq(input logic [3:0] a, input logic [15:0] d);
    logic p;
    logic [15:0] b;
    wr(a, d, p, b);
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d,
                    output logic [15:0] oe, output logic pop);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #5;
    d = rdata; oe = rdata_oe; pop = buf_rd_pop;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse_intrq();
    @(negedge clk);
    intrq_req = 1'b1;
    @(negedge clk);
    intrq_req = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d, oe; logic p;
    check("R1 soft_rst", soft_rst, 0);
    check("R1 hob", hob, 0);
    check("R1 host_intrq", host_intrq, 0);
    rd(4'h6, d, oe, p);
    check("R1 devhead", d, 16'h00A0);
  endtask

  task automatic t_devhead();
    logic [15:0] d, oe; logic p;
    wrq(4'h6, 16'h0053);
    check("R7 head", head, 3);
    check("R7 lba_mode", lba_mode, 1);
    check("R7 dev_selected strap0 drv1", dev_selected, 0);
    rd(4'h6, d, oe, p);
    check("R7 readback", d, 16'h00F3);
    check("R7 oe", oe, 16'h00FF);
  endtask

  task automatic t_drvaddr();
    logic [15:0] d, oe; logic p;
    rd(4'hF, d, oe, p);
    check("R8 drvaddr h3 dev1", d, 16'h0071);
    check("R8 oe", oe, 16'h007F);
    media_wr_busy = 1'b1;
    rd(4'hF, d, oe, p);
    check("R8 write gate low", d, 16'h0031);
    media_wr_busy = 1'b0;
    wrq(4'h6, 16'h000A);
    rd(4'hF, d, oe, p);
    check("R8 drvaddr h10 dev0", d, 16'h0056);
  endtask

  task automatic t_hob();
    wrq(4'hE, 16'h0080);
    check("R2 hob set", hob, 1);
    check("R2 soft_rst stays 0", soft_rst, 0);
    wrq(4'h2, 16'h0011);
    check("R3 hob cleared by cmd write", hob, 0);
    wrq(4'hE, 16'h0080);
    wrq(4'h0, 16'h5555);
    check("R3 hob cleared by data write", hob, 0);
  endtask

  task automatic t_intr();
    logic [15:0] d, oe; logic p;
    wrq(4'h6, 16'h0000);
    wrq(4'hE, 16'h0000);
    pulse_intrq();
    check("R4 intrq selected unmasked", host_intrq, 1);
    wrq(4'hE, 16'h0002);
    check("R4 intrq masked", host_intrq, 0);
    wrq(4'hE, 16'h0000);
    check("R4 intrq unmasked again", host_intrq, 1);
    wrq(4'h6, 16'h0010);
    check("R4 intrq other device", host_intrq, 0);
    wrq(4'h6, 16'h0000);
    check("R4 intrq reselected", host_intrq, 1);
    drq = 1'b1;
    rd(4'h7, d, oe, p);
    drq = 1'b0;
    check("R5 status drq bit", d, 16'h0008);
    check("R5 status oe", oe, 16'h00FF);
    check("R5 intrq cleared by status read", host_intrq, 0);
  endtask

  task automatic t_srst();
    logic [15:0] d, oe; logic p;
    wrq(4'h6, 16'h0045);
    pulse_intrq();
    wrq(4'hE, 16'h0084);
    @(negedge clk);
    check("R6 soft_rst held", soft_rst, 1);
    check("R6 hob cleared", hob, 0);
    check("R6 intrq cleared", host_intrq, 0);
    pulse_intrq();
    @(negedge clk);
    check("R6 request ignored", host_intrq, 0);
    wrq(4'hE, 16'h0084);
    check("R6 hob stays 0 in reset", hob, 0);
    rd(4'h6, d, oe, p);
    check("R6 devhead kept", d, 16'h00E5);
    rd(4'hF, d, oe, p);
    check("R8 select bits idle in reset", d[1:0], 2'b11);
    wrq(4'hE, 16'h0000);
    check("R6 soft_rst released", soft_rst, 0);
    check("R6 no stale interrupt", host_intrq, 0);
  endtask

  task automatic t_data();
    logic [15:0] d, oe, bw; logic p;
    buf_rdata = 16'hBEEF;
    drq = 1'b1;
    rd(4'h0, d, oe, p);
    check("R9 word read", d, 16'hBEEF);
    check("R9 word oe", oe, 16'hFFFF);
    check("R9 pop", p, 1);
    ecc_byte = 1'b1;
    rd(4'h0, d, oe, p);
    check("R9 byte read", d, 16'h00EF);
    check("R9 byte oe", oe, 16'h00FF);
    wr(4'h0, 16'h1234, p, bw);
    check("R11 byte push", p, 1);
    check("R11 byte wdata", bw, 16'h0034);
    ecc_byte = 1'b0;
    wr(4'h0, 16'h1234, p, bw);
    check("R11 word push", p, 1);
    check("R11 word wdata", bw, 16'h1234);
    drq = 1'b0;
    rd(4'h0, d, oe, p);
    check("R10 read without drq", d, 16'h0000);
    check("R10 no pop", p, 0);
    wr(4'h0, 16'hAAAA, p, bw);
    check("R10 no push", p, 0);
  endtask

  initial begin
    rst_n = 1'b0; dev_strap = 1'b0; addr = 4'h0; rd_en = 1'b0; wr_en = 1'b0;
    wdata = '0; drq = 1'b0; ecc_byte = 1'b0; media_wr_busy = 1'b0;
    intrq_req = 1'b0; buf_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_devhead();
    t_drvaddr();
    t_hob();
    t_intr();
    t_srst();
    t_data();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule